// File: doc/BRIEF.md
# Low-Power Mode and Wake Controller

This block sequences a processor subsystem between normal running and two low-power states. In the suspend state the main oscillator is held off, but the device is not reset. A qualified event from the port-match logic, the timer or the comparator turns the oscillator back on, and execution continues from where it stopped. In the stop state the oscillator is also off. A stop-configuration bit, written beforehand, decides whether the core regulator keeps running. If it keeps running, RAM survives and any reset brings the device back. If it is shut down, only the reset pin or power-on reset can end the state, and RAM is reported as lost.

The controller runs on an always-on low-frequency clock. Port pins and the comparator output are asynchronous, so they pass through a synchronizer chain of `SYNC_STAGES` flops before they are qualified. Timer overflow and the non-power-on reset requests arrive as single-cycle strobes in the controller's clock domain. Power-on reset (`porN`) is an asynchronous, active-low reset of the whole controller.

Top module: `lpwr_wake_ctl`

## Requirements
- R1: While `porN` is low, and in the first cycle after it is released, `oscEn`=1, `regEn`=1, `ramKept`=1, `wakeReq`=0 and `rstReq`=0. The stop-configuration bit is cleared.
- R2: A `suspendWr` pulse while running sets `oscEn` to 0 on the next clock edge. `regEn` stays 1 and `ramKept` becomes 1.
- R3: Each port has an ignore mask, where mask bit 1 excludes that pin. A port matches when at least one of its pins is not excluded and every included pin equals its match bit. A port whose pins are all excluded never matches. A match on either port wakes the device from suspend on the (`SYNC_STAGES`+1)-th clock edge after the pins change.
- R4: A `tmrOvf` pulse wakes the device from suspend on the next edge only when `tmrAltClk`=1, meaning the timer runs from a clock other than the main oscillator. With `tmrAltClk`=0 the overflow has no effect.
- R5: A low `cmpOut`, after synchronization, wakes the device from suspend.
- R6: A suspend wake sets `oscEn` back to 1 together with a one-cycle `wakeReq` pulse. `rstReq` stays 0 during a suspend wake.
- R7: `stopWr` while the stop-configuration bit is 0 gives `oscEn`=0, `regEn`=1 and `ramKept`=1. A pulse on `rstPin` or `rstOther` exits this state, with `oscEn`=1 and a one-cycle `rstReq`.
- R8: A `cfgWr` while running loads `cfgData` into the stop-configuration bit. `stopWr` with that bit set to 1 gives `oscEn`=0, `regEn`=0 and `ramKept`=0. In this state `rstOther` is ignored and `regEn` stays 0. A `rstPin` pulse exits the state with `regEn`=1, `oscEn`=1 and a one-cycle `rstReq`. `ramKept` stays 0 until the next entry into suspend or regulator-on stop.
- R9: Port match, qualified timer overflow and a low comparator output have no effect in either stop state.
- R10: A `rstPin` or `rstOther` pulse while running or suspended produces a one-cycle `rstReq`, leaves or keeps the device running, and clears the stop-configuration bit.
- R11: When several requests arrive in the same running cycle, reset takes priority over stop, and stop takes priority over suspend.
- R12: `porN` low forces the running state from any state, including regulator-off stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-frequency clock |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| suspendWr | input | 1 | Strobe: write 1 to the suspend bit |
| stopWr | input | 1 | Strobe: stop request |
| cfgWr | input | 1 | Strobe: write the stop-configuration bit |
| cfgData | input | 1 | Value written by `cfgWr` (1 = regulator off in stop) |
| p0Pins | input | PORT_W | Port 0 pin levels, asynchronous |
| p1Pins | input | PORT_W | Port 1 pin levels, asynchronous |
| p0Match | input | PORT_W | Port 0 match values |
| p1Match | input | PORT_W | Port 1 match values |
| p0Ign | input | PORT_W | Port 0 ignore mask (1 = pin excluded) |
| p1Ign | input | PORT_W | Port 1 ignore mask (1 = pin excluded) |
| tmrOvf | input | 1 | Timer overflow strobe |
| tmrAltClk | input | 1 | 1 = timer runs from a clock other than the main oscillator |
| cmpOut | input | 1 | Comparator output, asynchronous, wakes when low |
| rstPin | input | 1 | Reset-pin request strobe |
| rstOther | input | 1 | Strobe for any other reset source |
| oscEn | output | 1 | Main oscillator enable |
| regEn | output | 1 | Core regulator enable |
| wakeReq | output | 1 | One-cycle pulse on a suspend wake |
| rstReq | output | 1 | One-cycle pulse when a reset is accepted |
| ramKept | output | 1 | 0 once RAM has lost power in regulator-off stop |

## Verification
The port-match logic is swept over every combination of pin level, match value and ignore mask of a three-pin port. This sweep separates a pin mismatch from an excluded pin, and it shows that an all-excluded port never matches. Single-source patterns on the timer overflow, with both clock-select values, and on the comparator show whether each wake path is qualified on its own, apart from the port logic. The same wake and reset stimuli are then applied in both stop states, which tells the reset-only exit of regulator-on stop apart from the pin-only exit of regulator-off stop. Finally, simultaneous requests in one cycle expose the order of priority.

// File: rtl/lpwr_pkg.sv
package lpwr_pkg;

  typedef enum logic [1:0] {
    PM_RUN     = 2'd0,
    PM_SUSP    = 2'd1,
    PM_STOP    = 2'd2,
    PM_STOPOFF = 2'd3
  } pmState_t;

  // strobes from the control FSM to the datapath registers
  typedef struct packed {
    logic cfgLoad;
    logic cfgClear;
    logic ramSet;
    logic ramClr;
  } pmStrobe_t;

endpackage

// File: rtl/lpwr_wake_dp.sv
module lpwr_wake_dp
  import lpwr_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  pmStrobe_t         strb,
  input  logic              cfgData,
  input  logic [PORT_W-1:0] p0Pins,
  input  logic [PORT_W-1:0] p1Pins,
  input  logic [PORT_W-1:0] p0Match,
  input  logic [PORT_W-1:0] p1Match,
  input  logic [PORT_W-1:0] p0Ign,
  input  logic [PORT_W-1:0] p1Ign,
  input  logic              tmrOvf,
  input  logic              tmrAltClk,
  input  logic              cmpOut,
  output logic              suspWake,
  output logic              stopCfg,
  output logic              ramKept
);

  localparam int VEC_W = 2 * PORT_W + 1;
  localparam logic [VEC_W-1:0] SYNC_INIT = {1'b1, {(2 * PORT_W){1'b0}}};

  logic [VEC_W-1:0] syncPipe [SYNC_STAGES];
  logic [VEC_W-1:0] rawVec;
  logic [VEC_W-1:0] syncVec;

  assign rawVec = {cmpOut, p1Pins, p0Pins};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) syncPipe[s] <= SYNC_INIT;
        else       syncPipe[s] <= rawVec;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) syncPipe[s] <= SYNC_INIT;
        else       syncPipe[s] <= syncPipe[s-1];
      end
    end
  end

  assign syncVec = syncPipe[SYNC_STAGES-1];

  function automatic logic portHit(input logic [PORT_W-1:0] pins,
                                   input logic [PORT_W-1:0] match,
                                   input logic [PORT_W-1:0] ign);
    logic [PORT_W-1:0] used;
    used = ~ign;
    return (|used) && (((pins ^ match) & used) == '0);
  endfunction

  logic p0Hit, p1Hit, cmpLow, tmrHit;

  assign p0Hit  = portHit(syncVec[PORT_W-1:0], p0Match, p0Ign);
  assign p1Hit  = portHit(syncVec[2*PORT_W-1:PORT_W], p1Match, p1Ign);
  assign cmpLow = ~syncVec[VEC_W-1];
  assign tmrHit = tmrOvf & tmrAltClk;

  assign suspWake = p0Hit | p1Hit | tmrHit | cmpLow;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stopCfg <= 1'b0;
      ramKept <= 1'b1;
    end else begin
      if (strb.cfgClear)     stopCfg <= 1'b0;
      else if (strb.cfgLoad) stopCfg <= cfgData;
      if (strb.ramClr)       ramKept <= 1'b0;
      else if (strb.ramSet)  ramKept <= 1'b1;
    end
  end

endmodule

// File: rtl/lpwr_wake_fsm.sv
module lpwr_wake_fsm
  import lpwr_pkg::*;
(
  input  logic      clk,
  input  logic      porN,
  input  logic      suspendWr,
  input  logic      stopWr,
  input  logic      cfgWr,
  input  logic      rstPin,
  input  logic      rstOther,
  input  logic      suspWake,
  input  logic      stopCfg,
  output pmStrobe_t strb,
  output logic      oscEn,
  output logic      regEn,
  output logic      wakeReq,
  output logic      rstReq
);

  pmState_t state, stateNxt;
  logic wakeNxt, rstNxt, rstAny;

  assign rstAny = rstPin | rstOther;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    wakeNxt  = 1'b0;
    rstNxt   = 1'b0;
    case (state)
      PM_RUN: begin
        if (rstAny) begin
          rstNxt        = 1'b1;
          strb.cfgClear = 1'b1;
        end else if (stopWr) begin
          stateNxt = stopCfg ? PM_STOPOFF : PM_STOP;
          if (stopCfg) strb.ramClr = 1'b1;
          else         strb.ramSet = 1'b1;
        end else if (suspendWr) begin
          stateNxt    = PM_SUSP;
          strb.ramSet = 1'b1;
        end else if (cfgWr) begin
          strb.cfgLoad = 1'b1;
        end
      end
      PM_SUSP: begin
        if (rstAny) begin
          stateNxt      = PM_RUN;
          rstNxt        = 1'b1;
          strb.cfgClear = 1'b1;
        end else if (suspWake) begin
          stateNxt = PM_RUN;
          wakeNxt  = 1'b1;
        end
      end
      PM_STOP: begin
        if (rstAny) begin
          stateNxt      = PM_RUN;
          rstNxt        = 1'b1;
          strb.cfgClear = 1'b1;
        end
      end
      PM_STOPOFF: begin
        if (rstPin) begin
          stateNxt      = PM_RUN;
          rstNxt        = 1'b1;
          strb.cfgClear = 1'b1;
        end
      end
      default: stateNxt = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state   <= PM_RUN;
      wakeReq <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      state   <= stateNxt;
      wakeReq <= wakeNxt;
      rstReq  <= rstNxt;
    end
  end

  assign oscEn = (state == PM_RUN);
  assign regEn = (state != PM_STOPOFF);

endmodule

// File: rtl/lpwr_wake_ctl.sv
module lpwr_wake_ctl
  import lpwr_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              suspendWr,
  input  logic              stopWr,
  input  logic              cfgWr,
  input  logic              cfgData,
  input  logic [PORT_W-1:0] p0Pins,
  input  logic [PORT_W-1:0] p1Pins,
  input  logic [PORT_W-1:0] p0Match,
  input  logic [PORT_W-1:0] p1Match,
  input  logic [PORT_W-1:0] p0Ign,
  input  logic [PORT_W-1:0] p1Ign,
  input  logic              tmrOvf,
  input  logic              tmrAltClk,
  input  logic              cmpOut,
  input  logic              rstPin,
  input  logic              rstOther,
  output logic              oscEn,
  output logic              regEn,
  output logic              wakeReq,
  output logic              rstReq,
  output logic              ramKept
);

  pmStrobe_t strb;
  logic suspWake, stopCfg;

  lpwr_wake_dp #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .porN(porN), .strb(strb), .cfgData(cfgData),
    .p0Pins(p0Pins), .p1Pins(p1Pins), .p0Match(p0Match), .p1Match(p1Match),
    .p0Ign(p0Ign), .p1Ign(p1Ign), .tmrOvf(tmrOvf), .tmrAltClk(tmrAltClk),
    .cmpOut(cmpOut), .suspWake(suspWake), .stopCfg(stopCfg), .ramKept(ramKept)
  );

  lpwr_wake_fsm u_fsm (
    .clk(clk), .porN(porN), .suspendWr(suspendWr), .stopWr(stopWr),
    .cfgWr(cfgWr), .rstPin(rstPin), .rstOther(rstOther),
    .suspWake(suspWake), .stopCfg(stopCfg), .strb(strb),
    .oscEn(oscEn), .regEn(regEn), .wakeReq(wakeReq), .rstReq(rstReq)
  );

endmodule

// File: rtl/lpwr_wake_chk.sv
module lpwr_wake_chk (
  input logic clk,
  input logic porN,
  input logic rstPin,
  input logic oscEn,
  input logic regEn,
  input logic wakeReq,
  input logic rstReq,
  input logic ramKept
);

  // R8
  reg_off_osc_off_chk: assert property (@(posedge clk) disable iff (!porN)
    !regEn |-> !oscEn);

  // R8
  reg_off_sticky_chk: assert property (@(posedge clk) disable iff (!porN)
    (!regEn && !rstPin) |=> !regEn);

  // R8
  reg_return_by_reset_chk: assert property (@(posedge clk) disable iff (!porN)
    $rose(regEn) |-> (rstReq && oscEn));

  // R8
  reg_drop_ram_lost_chk: assert property (@(posedge clk) disable iff (!porN)
    $fell(regEn) |-> !ramKept);

  // R6
  wake_from_suspend_chk: assert property (@(posedge clk) disable iff (!porN)
    wakeReq |-> (oscEn && regEn && !rstReq && $past(!oscEn)));

  // R10
  reset_leaves_running_chk: assert property (@(posedge clk) disable iff (!porN)
    rstReq |-> oscEn);

endmodule

bind lpwr_wake_ctl lpwr_wake_chk u_chk (
  .clk(clk), .porN(porN), .rstPin(rstPin), .oscEn(oscEn), .regEn(regEn),
  .wakeReq(wakeReq), .rstReq(rstReq), .ramKept(ramKept)
);

// File: tb/lpwr_wake_ctl_bench.sv
module lpwr_wake_ctl_bench;

  localparam int W = 3;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic suspendWr = 0, stopWr = 0, cfgWr = 0, cfgData = 0;
  logic [W-1:0] p0Pins = '0, p1Pins = '0, p0Match = '0, p1Match = '0;
  logic [W-1:0] p0Ign = '1, p1Ign = '1;
  logic tmrOvf = 0, tmrAltClk = 0, cmpOut = 1, rstPin = 0, rstOther = 0;
  logic oscEn, regEn, wakeReq, rstReq, ramKept;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lpwr_wake_ctl #(.PORT_W(W), .SYNC_STAGES(SYNC)) u_lpwr_wake_ctl (
    .clk(clk), .porN(porN), .suspendWr(suspendWr), .stopWr(stopWr),
    .cfgWr(cfgWr), .cfgData(cfgData), .p0Pins(p0Pins), .p1Pins(p1Pins),
    .p0Match(p0Match), .p1Match(p1Match), .p0Ign(p0Ign), .p1Ign(p1Ign),
    .tmrOvf(tmrOvf), .tmrAltClk(tmrAltClk), .cmpOut(cmpOut),
    .rstPin(rstPin), .rstOther(rstOther), .oscEn(oscEn), .regEn(regEn),
    .wakeReq(wakeReq), .rstReq(rstReq), .ramKept(ramKept)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseSusp();  suspendWr = 1; step(1); suspendWr = 0; endtask
  task automatic pulseStop();  stopWr = 1;    step(1); stopWr = 0;    endtask
  task automatic pulseOther(); rstOther = 1;  step(1); rstOther = 0;  endtask
  task automatic pulsePin();   rstPin = 1;    step(1); rstPin = 0;    endtask
  task automatic writeCfg(input logic v);
    cfgData = v; cfgWr = 1; step(1); cfgWr = 0;
  endtask

  function automatic logic expHit(input logic [W-1:0] pins,
                                  input logic [W-1:0] match,
                                  input logic [W-1:0] ign);
    logic [W-1:0] used;
    used = ~ign;
    return (used != 0) && (((pins ^ match) & used) == 0);
  endfunction

  initial begin
    step(2);
    // R1 reset state while held
    check("R1 oscEn", oscEn, 1'b1);
    check("R1 regEn", regEn, 1'b1);
    check("R1 ramKept", ramKept, 1'b1);
    check("R1 wakeReq", wakeReq, 1'b0);
    check("R1 rstReq", rstReq, 1'b0);
    porN = 1'b1;
    step(SYNC + 1);
    // R1 stop-configuration cleared: stop keeps regulator on
    pulseStop();
    check("R1 cfg cleared regEn", regEn, 1'b1);
    check("R7 oscEn in stop", oscEn, 1'b0);
    pulseOther();
    check("R7 exit by other reset", oscEn, 1'b1);
    check("R7 rstReq pulse", rstReq, 1'b1);
    step(1);
    check("R7 rstReq one cycle", rstReq, 1'b0);

    // R3 sweep over port 0, port 1 fully ignored
    for (int ig = 0; ig < 8; ig++) begin
      for (int mv = 0; mv < 8; mv++) begin
        for (int pv = 0; pv < 8; pv++) begin
          logic h;
          p0Ign = ig[W-1:0]; p0Match = mv[W-1:0]; p0Pins = pv[W-1:0];
          h = expHit(pv[W-1:0], mv[W-1:0], ig[W-1:0]);
          step(SYNC + 1);
          pulseSusp();
          check("R2 suspend entry", oscEn, 1'b0);
          step(1);
          check("R3 port0 match wake", oscEn, h);
          check("R6 wakeReq on match", wakeReq, h);
          if (!h) pulseOther();
          step(1);
        end
      end
    end
    p0Ign = '1;

    // R3 port 1 path and synchronizer latency
    p1Ign = 3'b100; p1Match = 3'b011; p1Pins = 3'b000;
    step(SYNC + 1);
    pulseSusp();
    check("R2 regEn stays on", regEn, 1'b1);
    check("R2 ramKept", ramKept, 1'b1);
    p1Pins = 3'b111;
    step(SYNC);
    check("R3 no wake before sync delay", oscEn, 1'b0);
    step(1);
    check("R3 port1 wake at sync+1", oscEn, 1'b1);
    check("R6 rstReq stays low", rstReq, 1'b0);
    p1Ign = '1;
    step(2);

    // R4 timer overflow qualification
    pulseSusp();
    tmrAltClk = 0; tmrOvf = 1; step(1); tmrOvf = 0;
    check("R4 overflow on main clock ignored", oscEn, 1'b0);
    tmrAltClk = 1; tmrOvf = 1; step(1); tmrOvf = 0;
    check("R4 overflow on alt clock wakes", oscEn, 1'b1);
    check("R6 wakeReq on overflow", wakeReq, 1'b1);
    step(1);
    check("R6 wakeReq one cycle", wakeReq, 1'b0);

    // R5 comparator low
    pulseSusp();
    cmpOut = 0;
    step(SYNC);
    check("R5 not yet", oscEn, 1'b0);
    step(1);
    check("R5 comparator low wakes", oscEn, 1'b1);
    cmpOut = 1;
    step(SYNC + 2);

    // R10 reset in suspend, clears configuration
    writeCfg(1'b1);
    pulseSusp();
    pulsePin();
    check("R10 reset exits suspend", oscEn, 1'b1);
    check("R10 rstReq", rstReq, 1'b1);
    check("R10 no wakeReq", wakeReq, 1'b0);
    pulseStop();
    check("R10 cfg cleared by reset", regEn, 1'b1);
    // R9 wake sources ignored in regulator-on stop
    tmrOvf = 1; step(1); tmrOvf = 0;
    cmpOut = 0; step(SYNC + 2); cmpOut = 1;
    check("R9 no wake in stop", oscEn, 1'b0);
    pulsePin();
    check("R7 exit by pin", oscEn, 1'b1);
    step(SYNC + 2);

    // R8 regulator-off stop
    writeCfg(1'b1);
    pulseStop();
    check("R8 regEn off", regEn, 1'b0);
    check("R8 oscEn off", oscEn, 1'b0);
    check("R8 ramKept lost", ramKept, 1'b0);
    pulseOther();
    check("R8 other reset ignored", regEn, 1'b0);
    check("R8 no rstReq", rstReq, 1'b0);
    p0Ign = 3'b000; p0Match = 3'b101; p0Pins = 3'b101;
    tmrOvf = 1; step(1); tmrOvf = 0;
    step(SYNC + 2);
    check("R9 no wake in reg-off stop", regEn, 1'b0);
    p0Ign = '1;
    pulsePin();
    check("R8 pin exit regEn", regEn, 1'b1);
    check("R8 pin exit oscEn", oscEn, 1'b1);
    check("R8 pin exit rstReq", rstReq, 1'b1);
    check("R8 ramKept still lost", ramKept, 1'b0);
    step(SYNC + 2);
    pulseSusp();
    check("R8 ramKept set by suspend entry", ramKept, 1'b1);
    pulseOther();

    // R11 priorities
    writeCfg(1'b1);
    stopWr = 1; suspendWr = 1; step(1); stopWr = 0; suspendWr = 0;
    check("R11 stop over suspend", regEn, 1'b0);
    pulsePin();
    writeCfg(1'b1);
    stopWr = 1; rstOther = 1; step(1); stopWr = 0; rstOther = 0;
    check("R11 reset over stop", oscEn, 1'b1);
    check("R11 reset over stop rstReq", rstReq, 1'b1);
    step(1);

    // R12 power-on reset from regulator-off stop
    writeCfg(1'b1);
    pulseStop();
    check("R12 in reg-off stop", regEn, 1'b0);
    #3 porN = 0;
    #2;
    check("R12 por forces regEn", regEn, 1'b1);
    check("R12 por forces oscEn", oscEn, 1'b1);
    check("R12 por ramKept", ramKept, 1'b1);
    step(1);
    porN = 1;
    step(2);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule